// File: doc/BRIEF.md
# Asynchronous SRAM controller with byte lanes

This block sits between an on-chip client and an external asynchronous static RAM of 262,144 words by 16 bits. The client hands over one word request at a time through a valid/ready handshake. Each request carries an 18-bit word address, a write flag, 16 bits of write data and a 2-bit lane mask. The controller turns that request into a pin-level read or write cycle. The RAM control pins are all active low: chip select, write enable, output enable and one strobe per byte lane. A read returns its word to the client with a one-cycle valid pulse.

All device timing minima are given as parameters in nanoseconds, together with the clock period. Package functions round each minimum up to whole clock cycles. The pad side of the shared data bus is split into an output word, an output-enable and an input word, so the tristate pad can live in the chip's IO ring.

The controller never drives the bus while the RAM may be driving it. After every read it leaves a gap with all strobes idle before the next cycle may start. A parameter chooses whether output enable is held high or low during writes. The write pulse length and the moment the data driver turns on both follow that choice.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, chip select, write enable, output enable and both lane strobes are high, the data driver is off, and `req_ready` and `rsp_valid` are low. `req_ready` rises one clock after reset is released.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the access sequence ends, and `req_valid` raised while `req_ready` is low has no effect.
- R3: A read drives chip select and output enable low and write enable high for RD = max(ceil(tAA/Tclk), ceil(tRC/Tclk)) cycles, where tAA is the address access time and tRC the read cycle time. Mask bit 0 maps to `mem_bl_n[0]`, which gates data bits 7:0, and mask bit 1 maps to `mem_bl_n[1]`, which gates bits 15:8; a strobe is low exactly when its mask bit is 1. The data driver stays off for the whole read.
- R4: Read data is sampled on the edge that ends the read phase. `rsp_valid` is high for exactly the one following cycle, so it first appears RD edges after the accepting edge. Lanes whose mask bit is 0 return zero.
- R5: After a read, all strobes stay high and `req_ready` stays low for GAP = ceil(tHZ/Tclk) cycles (at least 1), where tHZ is the device's bus release time. The data driver is never on in a cycle that directly follows a cycle with chip select and output enable low and write enable high.
- R6: With output enable held high during writes (`OE_LOW_WR`=0), a write drives chip select and write enable low and output enable high. The data driver is on from the first cycle, and write enable stays low for max(ceil(tWP/Tclk), ceil(tWC/Tclk), ceil(tDW/Tclk)) cycles; here tWP is the write pulse width, tWC the write cycle time and tDW the data setup time before the end of the write.
- R7: With output enable held low during writes (`OE_LOW_WR`=1), output enable stays low for the whole write. The data driver is off for the first ceil(tHZ/Tclk) cycles, and write enable stays low for max(ceil(tWP1/Tclk), ceil(tWC/Tclk), ceil(tHZ/Tclk)+ceil(tDW/Tclk)) cycles, where tWP1 is the write pulse width required with output enable low.
- R8: A write ends with chip select, write enable, output enable and both lane strobes going high on the same edge, and the data driver turning off on that edge. Only lanes whose mask bit is 1 are written, and a mask of 00 leaves the memory unchanged.
- R9: `mem_addr` equals the accepted request address, and the address and lane strobes hold steady for as long as chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read word, unselected lanes zero |
| mem_addr | output | 18 | RAM address pins |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_bl_n | output | 2 | RAM lane strobes, active low, bit 0 = low byte |
| mem_dq_o | output | 16 | Data toward the pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | 16 | Data from the pad |

## Verification
A wrong phase counter shows up within one access as a read response arriving on the wrong edge or as a write pulse of the wrong length. The bench counts both edge by edge. A bad state transition or stale driver enable shows up in the same cycle as the data driver overlapping a RAM read phase. It can also show up as a stray strobe while `req_ready` is high. A lane-strobe or write-data register error stays hidden until a later read of that address, so the vectors write and then read each lane pattern back.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_TURN
  } st_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int rd_len(input int t_aa, input int t_rc, input int clk_ns);
    return imax(ns2cyc(t_aa, clk_ns), ns2cyc(t_rc, clk_ns));
  endfunction

  // cycles the data driver waits after write enable falls
  function automatic int drv_delay(input int t_hz, input int clk_ns, input bit oe_low);
    return oe_low ? ns2cyc(t_hz, clk_ns) : 0;
  endfunction

  function automatic int wr_len(input int t_wp, input int t_wp1, input int t_wc,
                                input int t_dw, input int t_hz, input int clk_ns,
                                input bit oe_low);
    int pulse;
    int data;
    pulse = imax(ns2cyc(t_wc, clk_ns), oe_low ? ns2cyc(t_wp1, clk_ns) : ns2cyc(t_wp, clk_ns));
    data  = drv_delay(t_hz, clk_ns, oe_low) + ns2cyc(t_dw, clk_ns);
    return imax(pulse, data);
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt > CW'(1)) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign last = (cnt == CW'(1));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CW        = 3,
  parameter int RD_CYC    = 2,
  parameter int WR_CYC    = 2,
  parameter int GAP_CYC   = 1,
  parameter int DRV_CYC   = 0,
  parameter bit OE_LOW_WR = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [CW-1:0] cnt,
  input  logic          last,
  output logic          req_ready,
  output logic          acc,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          rd_sample,
  output logic          wr_end,
  output logic          drv_set,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n
);

  localparam logic [CW-1:0] RD_L   = CW'(RD_CYC);
  localparam logic [CW-1:0] WR_L   = CW'(WR_CYC);
  localparam logic [CW-1:0] GAP_L  = CW'(GAP_CYC);
  localparam logic [CW-1:0] DRV_AT = CW'(WR_CYC - DRV_CYC + 1);

  st_e st;

  always_comb begin
    req_ready = (st == ST_IDLE);
    acc       = req_ready && req_valid;
    rd_sample = (st == ST_READ) && last;
    wr_end    = (st == ST_WRITE) && last;
    load      = acc || rd_sample;
    load_val  = !acc ? GAP_L : (req_write ? WR_L : RD_L);
    drv_set   = (acc && req_write && (DRV_CYC == 0)) ||
                ((st == ST_WRITE) && !last && (cnt == DRV_AT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_INIT;
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
    end else begin
      case (st)
        ST_INIT: st <= ST_IDLE;
        ST_IDLE: begin
          if (req_valid) begin
            mem_cs_n <= 1'b0;
            if (req_write) begin
              st       <= ST_WRITE;
              mem_we_n <= 1'b0;
              mem_oe_n <= !OE_LOW_WR;
            end else begin
              st       <= ST_READ;
              mem_oe_n <= 1'b0;
            end
          end
        end
        ST_READ: begin
          if (last) begin
            st       <= ST_TURN;
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
          end
        end
        ST_TURN: begin
          if (last) st <= ST_IDLE;
        end
        ST_WRITE: begin
          if (last) begin
            st       <= ST_IDLE;
            mem_cs_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
          end
        end
        default: st <= ST_INIT;
      endcase
    end
  end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int AW    = 18,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             rd_sample,
  input  logic             wr_end,
  input  logic             drv_set,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_mask,
  input  logic [DW-1:0]    mem_dq_i,
  output logic [AW-1:0]    mem_addr,
  output logic [LANES-1:0] mem_bl_n,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata
);

  localparam int LW = DW / LANES;

  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    rd_word;

  // per-lane read gating: unrequested lanes come back as zero
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*LW +: LW] = mask_q[g] ? mem_dq_i[g*LW +: LW] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_bl_n  <= '1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_sample;
      if (rd_sample) rsp_rdata <= rd_word;
      if (acc) begin
        mem_addr <= req_addr;
        mem_bl_n <= ~req_mask;
        mem_dq_o <= req_wdata;
        mask_q   <= req_mask;
      end else if (rd_sample || wr_end) begin
        mem_bl_n <= '1;
      end
      if (wr_end) mem_dq_oe <= 1'b0;
      else if (drv_set) mem_dq_oe <= 1'b1;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW            = 18,
  parameter int DW            = 16,
  parameter int LANES         = 2,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AA_NS       = 15,
  parameter int T_RC_NS       = 15,
  parameter int T_WC_NS       = 15,
  parameter int T_WP_NS       = 12,
  parameter int T_WP1_NS      = 15,
  parameter int T_DW_NS       = 8,
  parameter int T_HZ_NS       = 7,
  parameter bit OE_LOW_WR     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_mask,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_cs_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic [LANES-1:0] mem_bl_n,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_i
);

  localparam int RD_CYC  = rd_len(T_AA_NS, T_RC_NS, CLK_PERIOD_NS);
  localparam int WR_CYC  = wr_len(T_WP_NS, T_WP1_NS, T_WC_NS, T_DW_NS, T_HZ_NS,
                                  CLK_PERIOD_NS, OE_LOW_WR);
  localparam int DRV_CYC = drv_delay(T_HZ_NS, CLK_PERIOD_NS, OE_LOW_WR);
  localparam int GAP_CYC = ns2cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int CNT_MAX = imax(imax(RD_CYC, WR_CYC), GAP_CYC);
  localparam int CW      = $clog2(CNT_MAX + 2);

  // internal events, named for the checker
  logic          acc;
  logic          load;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt;
  logic          last;
  logic          rd_sample;
  logic          wr_end;
  logic          drv_set;

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .last     (last)
  );

  asram_seq #(
    .CW        (CW),
    .RD_CYC    (RD_CYC),
    .WR_CYC    (WR_CYC),
    .GAP_CYC   (GAP_CYC),
    .DRV_CYC   (DRV_CYC),
    .OE_LOW_WR (OE_LOW_WR)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .cnt       (cnt),
    .last      (last),
    .req_ready (req_ready),
    .acc       (acc),
    .load      (load),
    .load_val  (load_val),
    .rd_sample (rd_sample),
    .wr_end    (wr_end),
    .drv_set   (drv_set),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n)
  );

  asram_dpath #(.AW(AW), .DW(DW), .LANES(LANES)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .rd_sample (rd_sample),
    .wr_end    (wr_end),
    .drv_set   (drv_set),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_bl_n  (mem_bl_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW    = 18,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_cs_n,
  input logic             mem_we_n,
  input logic             mem_oe_n,
  input logic [LANES-1:0] mem_bl_n,
  input logic             mem_dq_oe,
  input logic             rd_sample,
  input logic             wr_end
);

  a_r1_ready_gated: assert property (@(posedge clk) !rst_n |-> !req_ready);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_bl_n == '1));

  a_r2_take_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n));

  a_r4_rsp_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |=> rsp_valid);

  a_r4_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !mem_oe_n && mem_we_n) |=> !mem_dq_oe);

  a_r8_we_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  a_r8_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && mem_bl_n == '1));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_bl_n)));

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_bl_n  (mem_bl_n),
  .mem_dq_oe (mem_dq_oe),
  .rd_sample (rd_sample),
  .wr_end    (wr_end)
);

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;

  localparam int CLK_NS = 5;
  // expectations restated from the requirements at a 5 ns clock
  localparam int EXP_RD   = (15 + CLK_NS - 1) / CLK_NS;           // R3/R4
  localparam int EXP_GAP  = (7 + CLK_NS - 1) / CLK_NS;            // R5
  localparam int EXP_WP_H = (15 + CLK_NS - 1) / CLK_NS;           // R6: tWC dominates
  localparam int EXP_HZ   = (7 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_WP_L = EXP_HZ + (8 + CLK_NS - 1) / CLK_NS;   // R7: hz + dw dominates

  typedef struct packed {
    logic        wr;
    logic [17:0] addr;
    logic [15:0] data;
    logic [1:0]  mask;
    logic [15:0] expd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 18'h00001, 16'hA5A5, 2'b11, 16'h0000},
    '{1'b0, 18'h00001, 16'h0000, 2'b11, 16'hA5A5},
    '{1'b1, 18'h00001, 16'h1234, 2'b01, 16'h0000},
    '{1'b0, 18'h00001, 16'h0000, 2'b11, 16'hA534},
    '{1'b1, 18'h00001, 16'h7E00, 2'b10, 16'h0000},
    '{1'b0, 18'h00001, 16'h0000, 2'b10, 16'h7E00},
    '{1'b0, 18'h00001, 16'h0000, 2'b01, 16'h0034},
    '{1'b1, 18'h3FFC2, 16'hBEEF, 2'b11, 16'h0000},
    '{1'b0, 18'h3FFC2, 16'h0000, 2'b11, 16'hBEEF},
    '{1'b1, 18'h3FFC2, 16'h1111, 2'b00, 16'h0000},
    '{1'b0, 18'h3FFC2, 16'h0000, 2'b11, 16'hBEEF},
    '{1'b0, 18'h3FFC2, 16'h0000, 2'b00, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #(CLK_NS / 2.0) clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [17:0] mem_addr;
  logic [1:0]  mem_bl_n;

  logic        v1_valid = 1'b0;
  logic        r1_ready, r1_rsp, c1_cs_n, c1_we_n, c1_oe_n, c1_dq_oe;
  logic [15:0] r1_rdata, c1_dq_o;
  logic [17:0] c1_addr;
  logic [1:0]  c1_bl_n;

  asram_ctrl #(.CLK_PERIOD_NS(CLK_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_bl_n(mem_bl_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  asram_ctrl #(.CLK_PERIOD_NS(CLK_NS), .OE_LOW_WR(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(v1_valid), .req_ready(r1_ready),
    .req_write(1'b1), .req_addr(18'h00010), .req_wdata(16'hC0DE),
    .req_mask(2'b11), .rsp_valid(r1_rsp), .rsp_rdata(r1_rdata),
    .mem_addr(c1_addr), .mem_cs_n(c1_cs_n), .mem_we_n(c1_we_n),
    .mem_oe_n(c1_oe_n), .mem_bl_n(c1_bl_n), .mem_dq_o(c1_dq_o),
    .mem_dq_oe(c1_dq_oe), .mem_dq_i(16'h0000)
  );

  // small RAM model: low six address bits select the word
  logic [15:0] mdl [64];
  wire dev_drv = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = dev_drv ?
    {(!mem_bl_n[1] ? mdl[mem_addr[5:0]][15:8] : 8'hC3),
     (!mem_bl_n[0] ? mdl[mem_addr[5:0]][7:0]  : 8'hC3)} : 16'h5A5A;

  int nvec = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  // write/contention monitor for u0
  bit          in_wr = 1'b0, prev_rd = 1'b0;
  int          we_cnt = 0, drv_cnt = 0;
  logic [15:0] last_d;
  logic [1:0]  last_bl;
  logic [5:0]  last_a;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && dev_drv) chk(1'b0, "R3 driver during read", 1, 0);
      if (prev_rd && mem_dq_oe) chk(1'b0, "R5 driver after read", 1, 0);
      if (!mem_cs_n && !mem_we_n) begin
        we_cnt++;
        if (mem_dq_oe) drv_cnt++;
        last_d  = mem_dq_o;
        last_bl = mem_bl_n;
        last_a  = mem_addr[5:0];
        in_wr   = 1'b1;
      end else if (in_wr) begin
        chk(we_cnt == EXP_WP_H, "R6 we pulse", we_cnt, EXP_WP_H);
        chk(drv_cnt == EXP_WP_H, "R6 data cycles", drv_cnt, EXP_WP_H);
        chk(mem_cs_n && mem_oe_n && !mem_dq_oe && mem_bl_n == 2'b11,
            "R8 write end", {mem_cs_n, mem_oe_n, mem_dq_oe, mem_bl_n}, 5'b11011);
        if (!last_bl[0]) mdl[last_a][7:0]  = last_d[7:0];
        if (!last_bl[1]) mdl[last_a][15:8] = last_d[15:8];
        we_cnt = 0;
        drv_cnt = 0;
        in_wr = 1'b0;
      end
      prev_rd = dev_drv;
    end
  end

  task automatic issue(input vec_t v);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = v.addr;
    req_wdata = v.data;
    req_mask  = v.mask;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_addr == v.addr, "R9 address", mem_addr, v.addr);
    chk(mem_bl_n == ~v.mask, "R3 lane strobes", mem_bl_n, ~v.mask);
  endtask

  task automatic finish_read(input vec_t v);
    int k;
    k = 0;
    while (!rsp_valid && k < 20) begin
      @(negedge clk);
      k++;
      if (!rsp_valid) chk(mem_addr == v.addr && !mem_oe_n, "R9 held", mem_addr, v.addr);
    end
    chk(k == EXP_RD, "R4 latency", k, EXP_RD);
    chk(rsp_rdata == v.expd, "R4 data", rsp_rdata, v.expd);
    chk(mem_cs_n && mem_oe_n && !req_ready, "R5 gap start", {mem_cs_n, mem_oe_n, req_ready}, 3'b110);
    for (int g = 1; g < EXP_GAP; g++) begin
      @(negedge clk);
      chk(!req_ready && mem_cs_n, "R5 gap", req_ready, 0);
      chk(!rsp_valid, "R4 single pulse", rsp_valid, 0);
    end
    @(negedge clk);
    chk(req_ready, "R5 gap end", req_ready, 1);
  endtask

  task automatic run_vec(input vec_t v);
    issue(v);
    if (!v.wr) begin
      chk(!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R3 read strobes",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
      finish_read(v);
    end else begin
      chk(!mem_cs_n && !mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_o == v.data,
          "R6 write start", mem_dq_o, v.data);
      repeat (EXP_WP_H - 1) begin
        @(negedge clk);
        chk(mem_addr == v.addr && !mem_we_n, "R9 held", mem_addr, v.addr);
      end
      @(negedge clk);
      chk(mem_we_n && mem_cs_n && req_ready, "R8 released", {mem_we_n, mem_cs_n, req_ready}, 3'b111);
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL R2 watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 16'h0000;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state on both instances
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_bl_n == 2'b11 && !mem_dq_oe,
        "R1 strobes idle", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    chk(!req_ready && !rsp_valid, "R1 ready low", req_ready, 0);
    chk(c1_cs_n && c1_we_n && c1_oe_n && !c1_dq_oe && !r1_ready, "R1 second instance",
        {c1_cs_n, c1_we_n, c1_oe_n, c1_dq_oe, r1_ready}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after release", req_ready, 1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R2: valid raised while busy is not taken
    issue('{1'b0, 18'h00001, 16'h0000, 2'b11, 16'h7E34});
    req_valid = 1'b1;
    req_write = 1'b1;
    req_wdata = 16'h0000;
    req_mask  = 2'b11;
    @(negedge clk);
    chk(!req_ready, "R2 busy", req_ready, 0);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == 16'h7E34, "R2 read while busy", rsp_rdata, 16'h7E34);
    repeat (EXP_GAP + 1) @(negedge clk);
    run_vec('{1'b0, 18'h00001, 16'h0000, 2'b11, 16'h7E34});

    // R7: write with output enable held low on u1
    while (!r1_ready) @(negedge clk);
    v1_valid = 1'b1;
    @(negedge clk);
    v1_valid = 1'b0;
    for (int c = 1; c <= EXP_WP_L; c++) begin
      chk(!c1_we_n && !c1_cs_n && !c1_oe_n, "R7 strobes low", {c1_we_n, c1_cs_n, c1_oe_n}, 0);
      chk(c1_dq_oe == (c > EXP_HZ), "R7 driver delay", c1_dq_oe, (c > EXP_HZ));
      @(negedge clk);
    end
    chk(c1_we_n && c1_cs_n && c1_oe_n && !c1_dq_oe, "R8 end in oe-low mode",
        {c1_we_n, c1_cs_n, c1_oe_n, c1_dq_oe}, 4'b1110);
    chk(c1_dq_o == 16'hC0DE, "R7 data word", c1_dq_o, 16'hC0DE);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule